// File: doc/BRIEF.md
# Banked Data Memory Address Resolver

This block sits between the operand decode of a small 8-bit core and its data register file. Each cycle it takes the 8-bit file field of a byte- or bit-oriented instruction, together with the access flag, and forms a 12-bit data address. There are three ways to form it. With the flag set, the address is banked through a 4-bit bank register. With the flag clear, a forced bank is used that splits between low RAM and the special register area. With the flag clear, a low file field and extended mode on, the field is an offset added to pointer 2.

The block owns three 12-bit pointer registers and the bank register. Each pointer has five virtual addresses: plain, post-increment, post-decrement, pre-increment and plus-W. An access to one of these redirects the operand through that pointer, and the pointer steps when the access ends.

The resolved address, the memory enables and the read data are combinational in the operand inputs. Pointer and bank changes commit on the clock edge that ends the access. When an indirect access lands on another virtual register, the read returns zero and the write is dropped. When an indirect write lands on a pointer byte, it stores that byte and skips the pending step.

Top module: `dmem_addr_resolve`

## Requirements
- R1: With op_acc = 1 the direct address is {bank register, op_file}. Only when that address falls in the pointer window is it redirected.
- R2: With op_acc = 0 and op_file in 60h..7Fh the address is 0 followed by op_file (060h..07Fh). With op_file in 80h..FFh the address is F80h..FFFh.
- R3: With op_acc = 0 and op_file at or below 5Fh, the address is 000h..05Fh while ext_en = 0. While ext_en = 1 it is pointer 2 plus the zero-extended op_file, modulo 4096. ext_en has no effect on op_acc = 1 operands or on file fields of 60h and above.
- R4: Address map. Pointer k (k = 0, 1, 2) occupies FE0h + 8k .. FE0h + 8k + 6. The offsets are +0 plain, +1 post-increment, +2 post-decrement, +3 pre-increment, +4 plus-W, +5 pointer bits 7:0 and +6 pointer bits 11:8 (read back zero-extended). The bank register is at FF8h. Offset +7 and every other address go to memory.
- R5: A direct address on a virtual register makes the access indirect. Plain, post-increment and post-decrement address the pointer value. Pre-increment addresses pointer + 1. Plus-W addresses pointer + wreg, with wreg zero-extended. Plain and plus-W leave the pointer unchanged.
- R6: Post-increment and pre-increment add 1 to the pointer, and post-decrement subtracts 1, modulo 4096. The change is visible from the cycle after the access.
- R7: If an indirect access resolves to a virtual register address, rd_data is 00h, rd_en and wr_en stay 0 and no register changes. The pointer used still steps.
- R8: An indirect write that resolves to a pointer byte stores op_wdata into that byte. No pointer takes its pending step.
- R9: Accesses to pointer bytes and to the bank register are served inside the block. rd_en and wr_en stay 0, rd_data returns the register value, and a write updates it at the clock edge.
- R10: A synchronous reset clears all pointers and the bank register to zero.
- R11: With op_valid = 0, rd_en and wr_en are 0 and no pointer or bank register changes.
- R12: Indirect accesses through the pointer virtual addresses give the same address whether ext_en is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operand access takes place this cycle |
| op_file | input | 8 | File field of the instruction |
| op_acc | input | 1 | Access flag: 1 banked, 0 forced bank |
| op_wr | input | 1 | The access writes its result |
| op_wdata | input | 8 | Value written by the access |
| ext_en | input | 1 | Extended offset mode enable |
| wreg | input | 8 | Working register value |
| mem_rdata | input | 8 | Read data of the register file at addr |
| addr | output | 12 | Resolved data address |
| rd_en | output | 1 | Register file read enable |
| wr_en | output | 1 | Register file write enable |
| rd_data | output | 8 | Operand read data |
| ptr_o | output | 36 | Pointer registers, 12 bits each, pointer k in bits 12k+11:12k |
| bsr_o | output | 4 | Bank register |

## Verification
The address, the two enables and the read data are due in the same cycle as the operand inputs. The monitor compares them 4 ns after the falling edge on which the driver applied the operand. Pointer and bank register values are due one clock edge later. Each access that changes them is followed by an idle cycle, and the monitor compares ptr_o and bsr_o there, together with the enables that must stay low.

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int BW = 4,
  parameter int NP = 3,
  parameter logic [AW-1:0] VBASE = 12'hFE0,
  parameter logic [AW-1:0] BSEL_ADDR = 12'hFF8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [7:0]           op_file,
  input  logic                 op_acc,
  input  logic                 op_wr,
  input  logic [DW-1:0]        op_wdata,
  input  logic                 ext_en,
  input  logic [DW-1:0]        wreg,
  input  logic [DW-1:0]        mem_rdata,
  output logic [AW-1:0]        addr,
  output logic                 rd_en,
  output logic                 wr_en,
  output logic [DW-1:0]        rd_data,
  output logic [NP-1:0][AW-1:0] ptr_o,
  output logic [BW-1:0]        bsr_o
);
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;
  localparam int NSLOT = 8;
  localparam logic [AW-1:0] WIN = AW'(NSLOT * NP);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] ptr_q [2**IW];
  logic [BW-1:0] bsr_q;

  logic [AW-1:0] da, ea, d_rel, e_rel, base;
  logic [IW-1:0] d_idx, e_idx;
  logic [2:0]    d_slot, e_slot;
  logic d_virt, e_win, e_virt, e_pb, e_bsr, null_acc, mem_hit, wr_pb;

  always_comb begin
    if (op_acc)
      da = {bsr_q, op_file};
    else if (op_file >= 8'h60)
      da = {{(AW-8){op_file[7]}}, op_file};
    else if (ext_en)
      da = ptr_q[2] + AW'(op_file);
    else
      da = AW'(op_file);
  end

  assign d_rel  = da - VBASE;
  assign d_idx  = d_rel[IW+2:3];
  assign d_slot = d_rel[2:0];
  assign d_virt = (d_rel < WIN) && (d_slot <= 3'd4);
  assign base   = ptr_q[d_idx];

  assign ea = !d_virt        ? da :
              d_slot == 3'd3 ? base + ONE :
              d_slot == 3'd4 ? base + AW'(wreg) :
                               base;

  assign e_rel  = ea - VBASE;
  assign e_idx  = e_rel[IW+2:3];
  assign e_slot = e_rel[2:0];
  assign e_win  = e_rel < WIN;
  assign e_virt = e_win && (e_slot <= 3'd4);
  assign e_pb   = e_win && (e_slot == 3'd5 || e_slot == 3'd6);
  assign e_bsr  = ea == BSEL_ADDR;

  assign null_acc = d_virt && e_virt;
  assign mem_hit  = !null_acc && !e_pb && !e_bsr;
  assign wr_pb    = op_valid && op_wr && !null_acc && e_pb;

  assign addr  = ea;
  assign rd_en = op_valid && mem_hit && !op_wr;
  assign wr_en = op_valid && mem_hit && op_wr;

  assign rd_data = null_acc ? '0 :
                   e_pb     ? (e_slot == 3'd5 ? ptr_q[e_idx][DW-1:0] : DW'(ptr_q[e_idx][AW-1:8])) :
                   e_bsr    ? DW'(bsr_q) :
                              mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 2**IW; k++) ptr_q[k] <= '0;
      bsr_q <= '0;
    end else if (op_valid) begin
      for (int k = 0; k < NP; k++) begin
        if (wr_pb && e_idx == IW'(k)) begin
          if (e_slot == 3'd5) ptr_q[k][7:0] <= op_wdata;
          else                ptr_q[k][AW-1:8] <= op_wdata[AW-9:0];
        end else if (d_virt && !wr_pb && d_idx == IW'(k)) begin
          case (d_slot)
            3'd1, 3'd3: ptr_q[k] <= ptr_q[k] + ONE;
            3'd2:       ptr_q[k] <= ptr_q[k] - ONE;
            default:    ;
          endcase
        end
      end
      if (op_wr && !null_acc && e_bsr) bsr_q <= op_wdata[BW-1:0];
    end
  end

  for (genvar k = 0; k < NP; k++) begin : g_out
    assign ptr_o[k] = ptr_q[k];
  end
  assign bsr_o = bsr_q;
endmodule

module resolve_chk (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [7:0]  op_file,
  input logic        op_acc,
  input logic        op_wr,
  input logic        ext_en,
  input logic [11:0] addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  rd_data,
  input logic [2:0][11:0] ptr_o,
  input logic [3:0]  bsr_o
);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> !rd_en && !wr_en);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(ptr_o) && $stable(bsr_o));

  p_bank_r1: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_acc && bsr_o != 4'hF |-> addr == {bsr_o, op_file});

  p_forced_r2: assert property (@(posedge clk) disable iff (rst)
    op_valid && !op_acc && op_file[7:5] == 3'b011 |-> addr == {4'h0, op_file});

  p_plain_low_r3: assert property (@(posedge clk) disable iff (rst)
    op_valid && !ext_en && !op_acc && op_file < 8'h60 |-> addr == {4'h0, op_file});

  p_postinc_r6: assert property (@(posedge clk) disable iff (rst)
    op_valid && !op_acc && op_file == 8'hE1 && !op_wr |=> ptr_o[0] == 12'($past(ptr_o[0]) + 12'd1));

  p_null_r7: assert property (@(posedge clk) disable iff (rst)
    op_valid && !op_acc && op_file == 8'hE0 && ptr_o[0] == 12'hFE8 |-> rd_data == 8'h00 && !rd_en && !wr_en);

  p_reset_r10: assert property (@(posedge clk)
    rst |=> ptr_o == '0 && bsr_o == 4'h0);
endmodule

bind dmem_addr_resolve resolve_chk u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_file(op_file), .op_acc(op_acc),
  .op_wr(op_wr), .ext_en(ext_en), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .rd_data(rd_data), .ptr_o(ptr_o), .bsr_o(bsr_o)
);

// File: tb/test_dmem_addr_resolve.sv
module test_dmem_addr_resolve;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0, op_acc = 1'b0, op_wr = 1'b0, ext_en = 1'b0;
  logic [7:0] op_file = '0, op_wdata = '0, wreg = '0;
  logic [7:0] mem_rdata = 8'hA5;
  logic [11:0] addr;
  logic rd_en, wr_en;
  logic [7:0] rd_data;
  logic [2:0][11:0] ptr_o;
  logic [3:0] bsr_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dmem_addr_resolve i_dmem_addr_resolve (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_file(op_file), .op_acc(op_acc),
    .op_wr(op_wr), .op_wdata(op_wdata), .ext_en(ext_en), .wreg(wreg),
    .mem_rdata(mem_rdata), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .rd_data(rd_data), .ptr_o(ptr_o), .bsr_o(bsr_o)
  );

  typedef struct {
    bit          kind;
    logic [11:0] ea;
    logic        erd, ewr;
    int          erdat;
    logic [11:0] p0, p1, p2;
    logic [3:0]  b;
    string       tag;
  } item_t;

  item_t q[$];

  task automatic acc(input logic [7:0] f, input logic a, input logic wr, input logic [7:0] wd,
                     input logic ex, input logic [7:0] w, input logic [11:0] ea,
                     input logic erd, input logic ewr, input int erdat, input string tag);
    item_t it;
    @(negedge clk);
    op_valid = 1'b1; op_file = f; op_acc = a; op_wr = wr; op_wdata = wd; ext_en = ex; wreg = w;
    it.kind = 1'b0; it.ea = ea; it.erd = erd; it.ewr = ewr; it.erdat = erdat;
    it.p0 = '0; it.p1 = '0; it.p2 = '0; it.b = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic st(input logic [11:0] p0, input logic [11:0] p1, input logic [11:0] p2,
                    input logic [3:0] b, input string tag);
    item_t it;
    @(negedge clk);
    op_valid = 1'b0; op_file = 8'hE1; op_wr = 1'b1; op_acc = 1'b0;
    it.kind = 1'b1; it.ea = '0; it.erd = 1'b0; it.ewr = 1'b0; it.erdat = -1;
    it.p0 = p0; it.p1 = p1; it.p2 = p2; it.b = b; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (it.kind == 1'b0) begin
          if (addr !== it.ea || rd_en !== it.erd || wr_en !== it.ewr ||
              (it.erdat >= 0 && rd_data !== it.erdat[7:0])) begin
            errors++;
            $display("FAIL %s: addr=%h rd=%b wr=%b rdata=%h expected addr=%h rd=%b wr=%b rdata=%0d",
                     it.tag, addr, rd_en, wr_en, rd_data, it.ea, it.erd, it.ewr, it.erdat);
          end
        end else begin
          if (ptr_o[0] !== it.p0 || ptr_o[1] !== it.p1 || ptr_o[2] !== it.p2 ||
              bsr_o !== it.b || rd_en !== 1'b0 || wr_en !== 1'b0) begin
            errors++;
            $display("FAIL %s: p0=%h p1=%h p2=%h bsr=%h rd=%b wr=%b expected p0=%h p1=%h p2=%h bsr=%h rd=0 wr=0",
                     it.tag, ptr_o[0], ptr_o[1], ptr_o[2], bsr_o, rd_en, wr_en,
                     it.p0, it.p1, it.p2, it.b);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    st(12'h000, 12'h000, 12'h000, 4'h0, "R10 reset state");
    acc(8'hF8, 0, 1, 8'h05, 0, 8'h00, 12'hFF8, 0, 0, 0, "R9 bank register write");
    st(12'h000, 12'h000, 12'h000, 4'h5, "R9 bank register stored");
    acc(8'h34, 1, 0, 8'h00, 0, 8'h00, 12'h534, 1, 0, 8'hA5, "R1 banked read");
    acc(8'h34, 1, 1, 8'h5A, 0, 8'h00, 12'h534, 0, 1, -1, "R1 banked write");
    acc(8'h6A, 0, 0, 8'h00, 0, 8'h00, 12'h06A, 1, 0, 8'hA5, "R2 forced low");
    acc(8'h7F, 0, 0, 8'h00, 0, 8'h00, 12'h07F, 1, 0, 8'hA5, "R2 forced low edge");
    acc(8'h80, 0, 0, 8'h00, 0, 8'h00, 12'hF80, 1, 0, 8'hA5, "R2 forced high edge");
    acc(8'h85, 0, 0, 8'h00, 0, 8'h00, 12'hF85, 1, 0, 8'hA5, "R2 forced high");
    acc(8'hE5, 0, 1, 8'h23, 0, 8'h00, 12'hFE5, 0, 0, -1, "R9 pointer low write");
    acc(8'hE6, 0, 1, 8'h01, 0, 8'h00, 12'hFE6, 0, 0, -1, "R9 pointer high write");
    st(12'h123, 12'h000, 12'h000, 4'h5, "R9 pointer stored");
    acc(8'hE5, 0, 0, 8'h00, 0, 8'h00, 12'hFE5, 0, 0, 8'h23, "R9 pointer low read");
    acc(8'hE6, 0, 0, 8'h00, 0, 8'h00, 12'hFE6, 0, 0, 8'h01, "R9 pointer high read");
    acc(8'hF5, 0, 1, 8'h00, 0, 8'h00, 12'hFF5, 0, 0, -1, "R4 pointer2 low");
    acc(8'hF6, 0, 1, 8'h02, 0, 8'h00, 12'hFF6, 0, 0, -1, "R4 pointer2 high");
    st(12'h123, 12'h000, 12'h200, 4'h5, "R4 pointer2 stored");
    acc(8'h10, 0, 0, 8'h00, 0, 8'h00, 12'h010, 1, 0, 8'hA5, "R3 extended off");
    acc(8'h10, 0, 0, 8'h00, 1, 8'h00, 12'h210, 1, 0, 8'hA5, "R3 extended offset");
    acc(8'h5F, 0, 0, 8'h00, 1, 8'h00, 12'h25F, 1, 0, 8'hA5, "R3 extended top offset");
    acc(8'h60, 0, 0, 8'h00, 1, 8'h00, 12'h060, 1, 0, 8'hA5, "R3 extended ignores 60h");
    acc(8'h10, 1, 0, 8'h00, 1, 8'h00, 12'h510, 1, 0, 8'hA5, "R3 extended ignores banked");
    acc(8'hF5, 0, 1, 8'hF0, 0, 8'h00, 12'hFF5, 0, 0, -1, "R9 pointer2 low");
    acc(8'hF6, 0, 1, 8'h0F, 0, 8'h00, 12'hFF6, 0, 0, -1, "R9 pointer2 high");
    acc(8'h20, 0, 0, 8'h00, 1, 8'h00, 12'h010, 1, 0, 8'hA5, "R3 extended wrap");
    acc(8'hE0, 0, 0, 8'h00, 0, 8'h00, 12'h123, 1, 0, 8'hA5, "R5 plain indirect");
    st(12'h123, 12'h000, 12'hFF0, 4'h5, "R5 plain keeps pointer");
    acc(8'hE1, 0, 0, 8'h00, 0, 8'h00, 12'h123, 1, 0, 8'hA5, "R5 post-increment address");
    st(12'h124, 12'h000, 12'hFF0, 4'h5, "R6 post-increment step");
    acc(8'hE2, 0, 0, 8'h00, 0, 8'h00, 12'h124, 1, 0, 8'hA5, "R5 post-decrement address");
    st(12'h123, 12'h000, 12'hFF0, 4'h5, "R6 post-decrement step");
    acc(8'hE3, 0, 0, 8'h00, 0, 8'h00, 12'h124, 1, 0, 8'hA5, "R5 pre-increment address");
    st(12'h124, 12'h000, 12'hFF0, 4'h5, "R6 pre-increment step");
    acc(8'hE4, 0, 0, 8'h00, 0, 8'h10, 12'h134, 1, 0, 8'hA5, "R5 plus-W address");
    st(12'h124, 12'h000, 12'hFF0, 4'h5, "R5 plus-W keeps pointer");
    acc(8'hE5, 0, 1, 8'hFF, 0, 8'h00, 12'hFE5, 0, 0, -1, "R9 pointer low");
    acc(8'hE6, 0, 1, 8'h0F, 0, 8'h00, 12'hFE6, 0, 0, -1, "R9 pointer high");
    acc(8'hE1, 0, 0, 8'h00, 0, 8'h00, 12'hFFF, 1, 0, 8'hA5, "R6 increment at top");
    st(12'h000, 12'h000, 12'hFF0, 4'h5, "R6 increment wraps");
    acc(8'hE2, 0, 0, 8'h00, 0, 8'h00, 12'h000, 1, 0, 8'hA5, "R6 decrement at zero");
    st(12'hFFF, 12'h000, 12'hFF0, 4'h5, "R6 decrement wraps");
    acc(8'hE5, 0, 1, 8'hE8, 0, 8'h00, 12'hFE5, 0, 0, -1, "R9 pointer at virtual");
    acc(8'hE0, 0, 0, 8'h00, 0, 8'h00, 12'hFE8, 0, 0, 8'h00, "R7 null read");
    acc(8'hE1, 0, 1, 8'h77, 0, 8'h00, 12'hFE8, 0, 0, 8'h00, "R7 null write");
    st(12'hFE9, 12'h000, 12'hFF0, 4'h5, "R7 null write stores nothing, pointer steps");
    acc(8'hE5, 0, 1, 8'hED, 0, 8'h00, 12'hFE5, 0, 0, -1, "R9 pointer at pointer1 low");
    acc(8'hE1, 0, 1, 8'h44, 0, 8'h00, 12'hFED, 0, 0, -1, "R8 write into other pointer");
    st(12'hFED, 12'h044, 12'hFF0, 4'h5, "R8 other pointer stored, no step");
    acc(8'hE5, 0, 1, 8'hE5, 0, 8'h00, 12'hFE5, 0, 0, -1, "R9 pointer at own low");
    acc(8'hE2, 0, 1, 8'h50, 0, 8'h00, 12'hFE5, 0, 0, -1, "R8 write into own pointer");
    st(12'hF50, 12'h044, 12'hFF0, 4'h5, "R8 own pointer stored, no decrement");
    st(12'hF50, 12'h044, 12'hFF0, 4'h5, "R11 idle cycle changes nothing");
    acc(8'hE0, 0, 0, 8'h00, 1, 8'h00, 12'hF50, 1, 0, 8'hA5, "R12 pointer0 under extended mode");
    acc(8'hE9, 0, 0, 8'h00, 1, 8'h00, 12'h044, 1, 0, 8'hA5, "R12 pointer1 under extended mode");
    st(12'hF50, 12'h045, 12'hFF0, 4'h5, "R12 pointer1 step under extended mode");
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
    #6;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule